// File: doc/BRIEF.md
# Register-File Bit-Pattern Transfer Unit

This unit moves the raw bit pattern of a 64-bit value between the floating-point register port and the integer register port of a core. On the way it applies a generalized bit reverse chosen by a 6-bit immediate. Any mix of bit, pair, nibble, byte, halfword or word swaps therefore happens in one operation, with no trip through memory. A shift immediate of zero gives a plain bitcast copy.

An opcode selects the direction: FP to FP, integer to FP, or FP to integer. It also selects whether the FP side is treated as a double or as a single-precision pattern. A single-precision source is first narrowed to its 32-bit pattern and zero-extended. A single-precision destination widens the low 32 bits of the reversed word back to double format. The widening and narrowing copy bits and flag no exceptions. When the record flag is set, the unit also returns a 4-bit condition-register field update, aimed at field 0 or field 1.

The datapath is combinational. One output register follows it, with valid/ready flow control on both sides.

Top module: `regxfer_unit`

## Requirements
- R1: `op` encodes the direction and the precision view as follows. 0: FP to FP, double to double. 1: FP to FP, single to single. 2: FP to FP, single to double. 3: FP to FP, double to single. 4: integer to FP, double. 5: integer to FP, single. 6: FP to integer, double. 7: FP to integer, single. `res_fp` is 1 for codes 0 to 5 and 0 for codes 6 and 7.
- R2: The reverse maps bit i of its 64-bit input to result bit i XOR `sh`. For example, `sh`=56 reverses all eight bytes, and `sh`=24 reverses the bytes inside each 32-bit half.
- R3: With `sh`=0, codes 0, 4 and 6 return their source unchanged.
- R4: For a single-precision source (codes 1, 2 and 7), the reverse input is 32 zero bits above the 32-bit narrowed pattern of `fp_src`.
- R5: For a single-precision destination (codes 1, 3 and 5), the result is the low 32 bits of the reversed word widened to double. Codes 6 and 7 return the reversed word itself.
- R6: Narrowing, when the double exponent e lies outside 874..896, takes the sign, bit 62 and bits 58..29. When e lies inside 874..896, it returns the sign, a zero exponent, and bits 51..29 of {1, fraction} shifted right by 897-e.
- R7: Widening keeps the sign. It adds 896 to an exponent in 1..254. It maps exponent 255 to 2047 and keeps the fraction. It maps a zero pattern to a signed zero. It normalizes a denormal: with its top set fraction bit at p, the exponent is 874+p.
- R8: Codes 6 and 7 with `rec`=1 give `cr_field`=0. The value `cr_val` is {LT, GT, EQ, SO}, where LT, GT and EQ come from a signed comparison of `res` with zero and SO equals `xer_so`.
- R9: Codes 0 to 5 with `rec`=1 give `cr_field`=1 and `cr_val` equal to `fpscr_sum`. `cr_we` equals the `rec` of the accepted operation.
- R10: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted operation appears on the outputs after the next clock edge. The outputs hold unchanged while `out_valid` is high and `out_ready` is low.
- R11: After reset, `out_valid` and `cr_we` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op | input | 3 | Direction and precision code |
| sh | input | 6 | Generalized-reverse control |
| rec | input | 1 | Record form: produce a CR update |
| fp_src | input | 64 | FP register operand |
| int_src | input | 64 | Integer register operand |
| xer_so | input | 1 | Summary-overflow bit for CR field 0 |
| fpscr_sum | input | 4 | FX, FEX, VX, OX summary bits for CR field 1 |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 64 | Result bit pattern |
| res_fp | output | 1 | Result targets the FP register file |
| cr_we | output | 1 | CR field update present |
| cr_field | output | 3 | CR field index (0 or 1) |
| cr_val | output | 4 | CR field value |

## Verification
The assertions assume that `op`, `sh` and the operands are stable and free of X whenever `in_valid` is high. They also assume that the consumer raises `out_ready` within a bounded time. The stimulus changes inputs only on the falling clock edge and holds each operation for exactly one accepting cycle. It draws FP operands from a mix of random patterns and chosen exponents: zeros, infinities, denormals and the narrowing band. Every exponent branch of the format conversions is reached this way. Back-pressure is applied only in a directed phase, and that phase releases `out_ready` after a few cycles.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  typedef enum logic [2:0] {
    OP_FF_DD = 3'd0,
    OP_FF_SS = 3'd1,
    OP_FF_SD = 3'd2,
    OP_FF_DS = 3'd3,
    OP_IF_D  = 3'd4,
    OP_IF_S  = 3'd5,
    OP_FI_D  = 3'd6,
    OP_FI_S  = 3'd7
  } xfer_op_e;

  typedef struct packed {
    logic src_int;
    logic src_sp;
    logic dst_int;
    logic dst_sp;
  } xfer_ctl_t;

  function automatic xfer_ctl_t decode_op(input logic [2:0] op);
    xfer_ctl_t c;
    c.src_int = (op == OP_IF_D) || (op == OP_IF_S);
    c.dst_int = (op == OP_FI_D) || (op == OP_FI_S);
    c.src_sp  = (op == OP_FF_SS) || (op == OP_FF_SD) || (op == OP_FI_S);
    c.dst_sp  = (op == OP_FF_SS) || (op == OP_FF_DS) || (op == OP_IF_S);
    return c;
  endfunction

  // Double pattern to single pattern, bit-select style with denormal band.
  function automatic logic [31:0] dp_narrow(input logic [63:0] d);
    logic [10:0] e;
    logic [52:0] m;
    e = d[62:52];
    if (e >= 11'd874 && e <= 11'd896) begin
      m = {1'b1, d[51:0]} >> (11'd897 - e);
      return {d[63], 8'h00, m[51:29]};
    end
    return {d[63], d[62], d[58:29]};
  endfunction

  // Single pattern to double pattern, exact.
  function automatic logic [63:0] sp_widen(input logic [31:0] w);
    logic [7:0]  e;
    logic [22:0] f;
    logic [63:0] t;
    int          p;
    e = w[30:23];
    f = w[22:0];
    if (e == 8'hFF) return {w[31], 11'h7FF, f, 29'b0};
    if (e != 8'h00) return {w[31], 11'({3'b000, e} + 11'd896), f, 29'b0};
    if (f == 23'b0) return {w[31], 63'b0};
    p = 0;
    for (int i = 0; i < 23; i++) if (f[i]) p = i;
    t = {41'b0, f} << (52 - p);
    return {w[31], 11'(874 + p), t[51:0]};
  endfunction

endpackage

// File: rtl/regxfer_grev.sv
module regxfer_grev #(
  parameter int W      = 64,
  parameter int STAGES = $clog2(W)
) (
  input  logic [W-1:0]      din,
  input  logic [STAGES-1:0] sh,
  output logic [W-1:0]      dout
);
  logic [W-1:0] stg [STAGES+1];
  assign stg[0] = din;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int BLK = 1 << k;
    logic [W-1:0] swapped;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign swapped[i] = stg[k][i ^ BLK];
    end
    assign stg[k+1] = sh[k] ? swapped : stg[k];
  end

  assign dout = stg[STAGES];
endmodule

// File: rtl/regxfer_srcsel.sv
module regxfer_srcsel
  import regxfer_pkg::*;
#(
  parameter int W = 64
) (
  input  xfer_ctl_t    ctl,
  input  logic [W-1:0] fp_src,
  input  logic [W-1:0] int_src,
  output logic [W-1:0] grev_in
);
  localparam int HALF = W / 2;
  always_comb begin
    if (ctl.src_int)     grev_in = int_src;
    else if (ctl.src_sp) grev_in = {{HALF{1'b0}}, dp_narrow(fp_src)};
    else                 grev_in = fp_src;
  end
endmodule

// File: rtl/regxfer_crgen.sv
module regxfer_crgen #(
  parameter int W     = 64,
  parameter int CRF_W = 3
) (
  input  logic             dst_int,
  input  logic [W-1:0]     result,
  input  logic             xer_so,
  input  logic [3:0]       fpscr_sum,
  output logic [CRF_W-1:0] field,
  output logic [3:0]       val
);
  logic neg, zero;
  assign neg  = result[W-1];
  assign zero = (result == '0);
  always_comb begin
    if (dst_int) begin
      field = CRF_W'(0);
      val   = {neg, !neg && !zero, zero, xer_so};
    end else begin
      field = CRF_W'(1);
      val   = fpscr_sum;
    end
  end
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int CRF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        op,
  input  logic [SH_W-1:0]   sh,
  input  logic              rec,
  input  logic [DATA_W-1:0] fp_src,
  input  logic [DATA_W-1:0] int_src,
  input  logic              xer_so,
  input  logic [3:0]        fpscr_sum,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] res,
  output logic              res_fp,
  output logic              cr_we,
  output logic [CRF_W-1:0]  cr_field,
  output logic [3:0]        cr_val
);
  localparam int HALF = DATA_W / 2;

  xfer_ctl_t         ctl;
  logic [DATA_W-1:0] grev_in, grev_out, result_c;
  logic [CRF_W-1:0]  field_c;
  logic [3:0]        val_c;
  logic              fire;

  assign ctl      = decode_op(op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  regxfer_srcsel #(.W(DATA_W)) u_src (
    .ctl(ctl), .fp_src(fp_src), .int_src(int_src), .grev_in(grev_in)
  );

  regxfer_grev #(.W(DATA_W), .STAGES(SH_W)) u_grev (
    .din(grev_in), .sh(sh), .dout(grev_out)
  );

  always_comb begin
    if (!ctl.dst_int && ctl.dst_sp) result_c = sp_widen(grev_out[HALF-1:0]);
    else                            result_c = grev_out;
  end

  regxfer_crgen #(.W(DATA_W), .CRF_W(CRF_W)) u_cr (
    .dst_int(ctl.dst_int), .result(result_c), .xer_so(xer_so),
    .fpscr_sum(fpscr_sum), .field(field_c), .val(val_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_fp    <= 1'b0;
      cr_we     <= 1'b0;
      cr_field  <= '0;
      cr_val    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      res       <= result_c;
      res_fp    <= !ctl.dst_int;
      cr_we     <= rec;
      cr_field  <= field_c;
      cr_val    <= val_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      cr_we     <= 1'b0;
    end
  end
endmodule

// File: rtl/regxfer_unit_chk.sv
module regxfer_unit_chk #(
  parameter int DATA_W = 64,
  parameter int SH_W   = 6,
  parameter int CRF_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        op,
  input logic [SH_W-1:0]   sh,
  input logic [DATA_W-1:0] int_src,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] res,
  input logic              res_fp,
  input logic              cr_we,
  input logic [CRF_W-1:0]  cr_field,
  input logic [3:0]        cr_val,
  input logic              fire,
  input logic [DATA_W-1:0] grev_in,
  input logic [DATA_W-1:0] grev_out
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(cr_val) && $stable(cr_we));
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r9_we_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> out_valid);
  a_r8_field0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cr_we && !res_fp |-> cr_field == CRF_W'(0) && $countones(cr_val[3:1]) == 1);
  a_r8_eq: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cr_we && !res_fp |-> cr_val[1] == (res == '0));
  a_r9_field1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cr_we && res_fp |-> cr_field == CRF_W'(1));
  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sh == '0 |-> grev_out == grev_in);
  a_r3_int_copy: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sh == '0 && op == 3'd4 |=> res == $past(int_src));
endmodule

bind regxfer_unit regxfer_unit_chk #(.DATA_W(DATA_W), .SH_W(SH_W), .CRF_W(CRF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .sh(sh), .int_src(int_src), .out_valid(out_valid), .out_ready(out_ready),
  .res(res), .res_fp(res_fp), .cr_we(cr_we), .cr_field(cr_field), .cr_val(cr_val),
  .fire(fire), .grev_in(grev_in), .grev_out(grev_out)
);

// File: tb/regxfer_unit_test.sv
module regxfer_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic        in_ready, out_valid, res_fp, cr_we, rec = 0, xer_so = 0;
  logic [2:0]  op = 0, cr_field;
  logic [5:0]  sh = 0;
  logic [63:0] fp_src = 0, int_src = 0, res;
  logic [3:0]  fpscr_sum = 0, cr_val;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regxfer_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .sh(sh), .rec(rec), .fp_src(fp_src), .int_src(int_src), .xer_so(xer_so),
    .fpscr_sum(fpscr_sum), .out_valid(out_valid), .out_ready(out_ready),
    .res(res), .res_fp(res_fp), .cr_we(cr_we), .cr_field(cr_field), .cr_val(cr_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_grev(input logic [63:0] v, input logic [5:0] s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[i ^ int'(s)];
    return r;
  endfunction

  function automatic logic [31:0] ref_narrow(input logic [63:0] d);
    int e;
    logic [63:0] m;
    e = int'(d[62:52]);
    if (e < 874 || e > 896) return {d[63:62], d[58:29]};
    m = ({12'b1, d[51:0]}) >> (897 - e);
    return {d[63], 8'h00, m[51:29]};
  endfunction

  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    int e;
    logic [23:0] f;
    e = int'(w[30:23]);
    if (e == 255) return {w[31], 11'h7FF, w[22:0], 29'b0};
    if (e > 0) return {w[31], 11'(e + 896), w[22:0], 29'b0};
    if (w[22:0] == 0) return {w[31], 63'b0};
    f = {1'b0, w[22:0]};
    e = 897;
    while (!f[23]) begin f = f << 1; e--; end
    return {w[31], 11'(e), f[22:0], 29'b0};
  endfunction

  // Issue one operation, check it one cycle later.
  task automatic run_op(input logic [2:0] o, input logic [5:0] s, input logic r,
                        input logic [63:0] fv, input logic [63:0] iv,
                        input logic so, input logic [3:0] fs);
    bit src_int, src_sp, dst_int, dst_sp;
    logic [63:0] gin, g, exp_r;
    logic [3:0] exp_cr;
    src_int = (o == 4 || o == 5);
    dst_int = (o == 6 || o == 7);
    src_sp  = (o == 1 || o == 2 || o == 7);
    dst_sp  = (o == 1 || o == 3 || o == 5);
    gin = src_int ? iv : (src_sp ? {32'b0, ref_narrow(fv)} : fv);
    g = ref_grev(gin, s);
    exp_r = (dst_sp && !dst_int) ? ref_widen(g[31:0]) : g;
    if (dst_int) exp_cr = {exp_r[63], !exp_r[63] && exp_r != 0, exp_r == 0, so};
    else         exp_cr = fs;
    @(negedge clk);
    op = o; sh = s; rec = r; fp_src = fv; int_src = iv; xer_so = so; fpscr_sum = fs;
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b1, "R10", 64'(out_valid), 64'd1);
    chk(res === exp_r, dst_sp ? "R5" : (src_sp ? "R4" : "R2"), res, exp_r);
    chk(res_fp === !dst_int, "R1", 64'(res_fp), 64'(!dst_int));
    chk(cr_we === r, "R9", 64'(cr_we), 64'(r));
    if (r) begin
      chk(cr_field === (dst_int ? 3'd0 : 3'd1), dst_int ? "R8" : "R9", 64'(cr_field), dst_int ? 64'd0 : 64'd1);
      chk(cr_val === exp_cr, dst_int ? "R8" : "R9", 64'(cr_val), 64'(exp_cr));
    end
  endtask

  function automatic logic [63:0] rand_fp();
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 5);
    case (k)
      0: v[62:52] = 11'(874 + $urandom_range(0, 22));
      1: v[62:52] = 11'h7FF;
      2: v[62:52] = 11'h000;
      3: v[62:52] = 11'(897 + $urandom_range(0, 253));
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic [63:0] rand_int();
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 5);
    if (k == 0) v = 0;
    else if (k == 1) v[30:23] = 8'h00;
    else if (k == 2) v[30:23] = 8'hFF;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    chk(cr_we === 1'b0, "R11", 64'(cr_we), 64'd0);
    chk(in_ready === 1'b1, "R11", 64'(in_ready), 64'd1);
    rst_n = 1;

    // R3: plain copies with sh=0
    run_op(3'd4, 6'd0, 1, 64'h0, 64'hDEADBEEF_01234567, 0, 4'hA);
    chk(res === 64'hDEADBEEF_01234567, "R3", res, 64'hDEADBEEF_01234567);
    run_op(3'd6, 6'd0, 1, 64'h8000_0000_0000_0001, 64'h0, 1, 4'h0);
    chk(cr_val === 4'b1001, "R8", 64'(cr_val), 64'b1001);
    run_op(3'd0, 6'd0, 0, 64'h4009_21FB_5444_2D18, 64'h0, 0, 4'h0);
    chk(res === 64'h4009_21FB_5444_2D18, "R3", res, 64'h4009_21FB_5444_2D18);
    // R2: byte-reversal immediates
    run_op(3'd4, 6'd56, 0, 0, 64'h0102030405060708, 0, 0);
    chk(res === 64'h0807060504030201, "R2", res, 64'h0807060504030201);
    run_op(3'd4, 6'd24, 0, 0, 64'h0102030405060708, 0, 0);
    chk(res === 64'h0403020108070605, "R2", res, 64'h0403020108070605);
    // R7: widening corners
    run_op(3'd5, 6'd0, 1, 0, 64'h3F800000, 0, 4'h5);
    chk(res === 64'h3FF0000000000000, "R7", res, 64'h3FF0000000000000);
    run_op(3'd5, 6'd0, 0, 0, 64'h00000001, 0, 0);
    chk(res === 64'h36A0000000000000, "R7", res, 64'h36A0000000000000);
    run_op(3'd5, 6'd0, 0, 0, 64'h7F800000, 0, 0);
    chk(res === 64'h7FF0000000000000, "R7", res, 64'h7FF0000000000000);
    run_op(3'd5, 6'd0, 0, 0, 64'h80000000, 0, 0);
    chk(res === 64'h8000000000000000, "R7", res, 64'h8000000000000000);
    // R6 / R4: narrowing corners
    run_op(3'd7, 6'd0, 1, 64'h3FF0000000000000, 0, 0, 0);
    chk(res === 64'h3F800000, "R6", res, 64'h3F800000);
    chk(cr_val === 4'b0100, "R8", 64'(cr_val), 64'b0100);
    run_op(3'd7, 6'd0, 0, 64'h3800000000000000, 0, 0, 0);
    chk(res === 64'h00400000, "R6", res, 64'h00400000);
    run_op(3'd7, 6'd32, 0, 64'h3FF0000000000000, 0, 0, 0);
    chk(res === 64'h3F80000000000000, "R4", res, 64'h3F80000000000000);
    run_op(3'd6, 6'd0, 1, 64'h0, 0, 0, 0);
    chk(cr_val === 4'b0010, "R8", 64'(cr_val), 64'b0010);

    // R10: back-pressure
    @(negedge clk);
    op = 3'd4; sh = 0; rec = 1; int_src = 64'h1111; in_valid = 1; out_ready = 0;
    @(negedge clk);
    chk(in_ready === 1'b0, "R10", 64'(in_ready), 64'd0);
    int_src = 64'h2222;
    repeat (3) @(negedge clk);
    chk(res === 64'h1111 && out_valid === 1'b1, "R10", res, 64'h1111);
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    chk(out_valid === 1'b0 && cr_we === 1'b0, "R10", 64'(out_valid), 64'd0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      run_op(3'($urandom_range(0, 7)), 6'($urandom), 1'($urandom),
             rand_fp(), rand_int(), 1'($urandom), 4'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule